// File: doc/BRIEF.md
# Sequential Sample Capture and Playback Buffer

This block records a fixed-length run of converter samples into an on-chip dual-port array and then streams the run back out in arrival order. A sample enters whenever the input strobe is high. The block writes it at a write pointer that begins at zero and steps by one. When the configured number of samples has been stored, the block stops accepting input and enters playback.

During playback a separate read pointer walks the array from zero upward. Each cycle with the downstream ready input high issues one read. The word and its valid flag emerge one cycle later. After the final word the block passes through a single idle cycle, emits a done pulse and re-arms for a fresh capture.

Writes and reads use independent address ports, so there is no shared address multiplexer. The whole block runs on the one system clock that also serves the converter interface. The sample count and array depth are parameters; the field setting is 12,000 samples in a 12,288-entry array.

Top module: `sample_loop_buf`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it falls, `mode` reads 2'b01 (capture) and `out_valid` and `done` are low.
- R2: In capture mode each cycle with `in_valid` high stores `in_data` at the write pointer. The write pointer starts at 0 and advances by one per stored sample; cycles with `in_valid` low store nothing.
- R3: The clock edge that stores sample number NSAMP (counting from one) switches `mode` to 2'b10 (playback).
- R4: `in_valid` has no effect while `mode` is 2'b10 or 2'b00. Such samples never appear in any later playback.
- R5: In playback, a cycle with `out_ready` high reads one word. The word appears on `out_data` with `out_valid` high exactly one cycle later.
- R6: In playback, a cycle with `out_ready` low issues no read. The read pointer holds, and `out_valid` is low in the following cycle.
- R7: Playback delivers exactly NSAMP words, in the order they were stored, from address 0 to address NSAMP-1.
- R8: `done` is high only in the cycle that carries the last word, and `mode` reads 2'b00 (idle) in that cycle. `mode` is 2'b01 again in the next cycle, with both pointers at 0.
- R9: A reset asserted during playback returns the block to capture at address 0. The next playback delivers only the samples captured after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for both array ports |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DW | Incoming sample |
| in_valid | input | 1 | Sample strobe |
| out_ready | input | 1 | Downstream permits one read this cycle |
| out_data | output | DW | Played-back sample |
| out_valid | output | 1 | `out_data` holds a played-back word |
| mode | output | 2 | 2'b01 capture, 2'b10 playback, 2'b00 idle |
| done | output | 1 | One-cycle pulse with the last played word |

## Verification
The sharp coincidence is the end of one playback colliding with the start of the next capture. The input strobe is kept running throughout playback, so a strobe lands on the idle cycle where `done` fires, and another lands on the very next cycle. The scoreboard queues a sample only when it was offered while `mode` showed capture. The second playback must therefore start with the sample offered right after the idle cycle, and it must contain none of the samples offered during playback or idle. A reset during a third playback is judged the same way: only post-reset samples may come back.

// File: rtl/sample_loop_buf.sv
module sample_loop_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  parameter int NSAMP = 2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic [1:0]    mode,
  output logic          done
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] M_IDLE = 2'b00;
  localparam logic [1:0] M_CAP  = 2'b01;
  localparam logic [1:0] M_PLAY = 2'b10;
  localparam logic [AW-1:0] LAST = AW'(NSAMP - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wa, ra;
  logic [1:0]    mode_q;

  wire wr_en   = (mode_q == M_CAP) && in_valid;
  wire rd_en   = (mode_q == M_PLAY) && out_ready;
  wire wr_last = (wa == LAST);
  wire rd_last = (ra == LAST);

  always_ff @(posedge clk)
    if (wr_en) mem[wa] <= in_data;

  always_ff @(posedge clk)
    if (rd_en) out_data <= mem[ra];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_CAP;
      wa        <= '0;
      ra        <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= rd_en;
      done      <= rd_en && rd_last;
      case (mode_q)
        M_CAP:
          if (wr_en) begin
            wa <= wr_last ? '0 : wa + 1'b1;
            if (wr_last) mode_q <= M_PLAY;
          end
        M_PLAY:
          if (rd_en) begin
            ra <= rd_last ? '0 : ra + 1'b1;
            if (rd_last) mode_q <= M_IDLE;
          end
        default: mode_q <= M_CAP;
      endcase
    end
  end

  assign mode = mode_q;

  p_mode_legal_r8: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'b11);

  p_wr_ptr_parked_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q != M_CAP) |-> (wa == '0));

  p_rd_ptr_parked_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q != M_PLAY) |-> (ra == '0));

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PLAY && !out_ready) |=> ($stable(ra) && !out_valid));

  p_play_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PLAY && $past(mode_q) == M_CAP) |-> $past(in_valid));

  p_done_with_last_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_valid && mode_q == M_IDLE));

  p_idle_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_IDLE) |=> (mode_q == M_CAP));
endmodule

// File: tb/sample_loop_buf_tb_top.sv
module sample_loop_buf_tb_top;
  localparam int DW = 16;
  localparam int NS = 8;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic out_valid;
  logic [1:0] mode;
  logic done;

  always #2.5 clk = ~clk;

  sample_loop_buf #(.DW(DW), .DEPTH(DP), .NSAMP(NS)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
    .mode(mode), .done(done));

  logic [DW-1:0] exp_q[$];
  bit last_q[$];
  int n_cmp = 0, n_bad = 0, n_done = 0;
  int cyc = 0, acc = 0;
  logic [DW-1:0] seq = 16'h3C00;
  bit drv_en = 0, vfull = 0, rdy_en = 0, rfull = 0;
  bit full_pulse = 0, done_prev = 0;
  logic [1:0] mode_prev = 2'b01;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // driver: offers samples, pushes the ones that land in capture mode
  always @(negedge clk) begin
    logic v;
    cyc <= cyc + 1;
    if (drv_en) begin
      v = vfull || (cyc % 3 != 1);
      in_valid <= v;
      in_data  <= seq;
      if (v && mode == 2'b01) begin
        exp_q.push_back(seq);
        last_q.push_back(acc == NS - 1);
        full_pulse <= (acc == NS - 1);
        acc = (acc == NS - 1) ? 0 : acc + 1;
      end else full_pulse <= 1'b0;
      seq = seq + 16'd7;
    end else begin
      in_valid   <= 1'b0;
      full_pulse <= 1'b0;
    end
    out_ready <= rdy_en && (rfull || (cyc % 4 != 3));
  end

  // monitor: scoreboard compare
  always @(negedge clk) begin
    bit exp_ov;
    if (rst) begin
      mode_prev <= 2'b01;
      done_prev <= 1'b0;
    end else begin
      exp_ov = (mode_prev == 2'b10) && out_ready;
      chk(out_valid == exp_ov, "R5/R6 out_valid timing", out_valid, exp_ov);
      if (done_prev) chk(mode == 2'b01, "R8 re-arm to capture", mode, 1);
      if (full_pulse) chk(mode == 2'b10, "R3 playback after NSAMP", mode, 2);
      if (out_valid) begin
        if (exp_q.size() == 0) chk(0, "R4/R7 unexpected word", out_data, 0);
        else begin
          logic [DW-1:0] e;
          bit l;
          e = exp_q.pop_front();
          l = last_q.pop_front();
          chk(out_data == e, "R2/R7 playback data", out_data, e);
          chk(done == l, "R8 done on last word", done, l);
          if (done) chk(mode == 2'b00, "R8 idle with done", mode, 0);
        end
      end else if (done) chk(0, "R8 done without word", 1, 0);
      if (done) n_done++;
      mode_prev <= mode;
      done_prev <= done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(mode == 2'b01, "R1 reset mode", mode, 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);

    // round 1: gappy capture, stall at start of playback (R6)
    @(posedge clk); drv_en = 1;
    do @(negedge clk); while (mode != 2'b10);
    repeat (5) @(negedge clk);
    // round 1 playback with in_valid still running (R4), then
    // round 2 capture starts on the cycle after done
    @(posedge clk); rdy_en = 1;
    wait (n_done == 2);

    // round 3: reset in the middle of playback (R9)
    do @(negedge clk); while (mode != 2'b10);
    repeat (3) @(negedge clk);
    @(posedge clk); drv_en = 0; rdy_en = 0;
    @(negedge clk); rst <= 1'b1;
    repeat (2) @(negedge clk);
    rst <= 1'b0;
    @(posedge clk); exp_q.delete(); last_q.delete();
    @(negedge clk);
    chk(mode == 2'b01, "R9 capture after reset", mode, 1);
    chk(out_valid == 1'b0, "R9 no word after reset", out_valid, 0);
    @(posedge clk); vfull = 1; rfull = 1; drv_en = 1; rdy_en = 1;
    wait (n_done == 3);
    @(posedge clk); drv_en = 0; rdy_en = 0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);
    wrap_up();
  end
endmodule